// File: doc/BRIEF.md
# Attribute Space Decoder with Soft-Reset Busy Timer

This block answers host accesses to the attribute space of a removable storage card. It serves two things. The first is a read-only card information area, 256 bytes wide, that holds one byte on each even address. The second is a short bank of byte-wide configuration registers placed above that area. An access is claimed only when the attribute-space select and the low card enable are both active and exactly one data strobe is active. All other addresses in attribute space read as all ones.

The first configuration register carries two control bits: a soft-reset bit and an interrupt-enable bit. Writing the soft-reset bit returns the other configuration state to its defaults. It also drops the ready line. The ready line then stays low while the bit is held, and for a fixed number of clocks after the bit is cleared. The same ready line reports busy during a hardware reset and for the same recovery time after that reset ends. The interrupt output follows the drive's request only while interrupts are enabled. Otherwise it is driven low.

Top module: `attr_space_ctl`

## Requirements
- R1: A read is claimed only when reg_sel_n=0, ce_lo_n=0, oe_n=0 and we_n=1. A write is claimed only when reg_sel_n=0, ce_lo_n=0, we_n=0 and oe_n=1. Any other strobe combination, including oe_n and we_n both low, changes nothing and yields rdata=0xFF.
- R2: A read of even address 2*i with i<128 returns the information byte (i XOR 0xA5) on rdata, one rising edge after the read is sampled.
- R3: A read of an odd address below 0x100 returns 0xFF.
- R4: A write to any address below 0x100 leaves every configuration register unchanged.
- R5: Configuration register n (n=0..3) sits at address 0x200+2*n. It is readable and writable as 8 bits. In register 0, bit 7 is soft reset and bit 6 is interrupt enable.
- R6: Odd addresses in the register range, and addresses that fall in neither area, read 0xFF. Writes to them are ignored.
- R7: ready is 0 while rst_n is low. It becomes 1 exactly 16 rising edges after rst_n is released.
- R8: A write to register 0 with bit 7 set drives ready to 0 from that edge onward. It leaves register 0 equal to 0x80 and clears registers 1 to 3.
- R9: After bit 7 of register 0 is cleared, ready stays 0 for 16 more rising edges and then returns to 1.
- R10: host_irq equals dev_irq while bit 6 of register 0 is 1. Otherwise host_irq is 0.
- R11: rdata is 0xFF in every cycle that does not follow a claimed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| reg_sel_n | input | 1 | Attribute-space select, active low |
| ce_lo_n | input | 1 | Low-byte card enable, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 10 | Attribute-space byte address |
| wdata | input | 8 | Write data |
| dev_irq | input | 1 | Interrupt request from the drive |
| rdata | output | 8 | Read data, registered |
| ready | output | 1 | 1 = card ready, 0 = busy |
| host_irq | output | 1 | Interrupt to the host, gated by the enable bit |

## Verification
Each result is due at a known point:
- Read data appears one rising edge after the strobes are sampled.
- A register write takes effect at the edge that samples it.
- ready falls at the edge that sets soft reset and rises 16 edges after the edge that clears it.
- host_irq follows dev_irq within the same cycle.

The bench changes inputs 4 ns after a rising edge and lets a reference model advance on every rising edge. It compares all outputs at the following falling edge, so each result is checked in the cycle it is due and never earlier.

// File: rtl/attr_space_pkg.sv
package attr_space_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_INFO = 2'd1,
      RGN_CFG  = 2'd2
   } region_e;

   // information byte stored at index idx (address 2*idx)
   function automatic logic [BYTE_W-1:0] info_byte(input int idx, input logic [BYTE_W-1:0] key);
      logic [BYTE_W-1:0] b;
      b = BYTE_W'(idx);
      return b ^ key;
   endfunction
endpackage

// File: rtl/attr_decode.sv
module attr_decode
   import attr_space_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int INFO_SPAN = 256,
   parameter int CFG_BASE  = 'h200,
   parameter int NUM_CFG   = 4,
   localparam int IDX_W    = $clog2(NUM_CFG)
) (
   input  logic              reg_sel_n,
   input  logic              ce_lo_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              rd_acc,
   output logic              wr_acc,
   output region_e           region,
   output logic              odd,
   output logic [IDX_W-1:0]  cfg_idx
);
   localparam logic [ADDR_W:0] INFO_HI = (ADDR_W+1)'(INFO_SPAN);
   localparam logic [ADDR_W:0] CFG_LO  = (ADDR_W+1)'(CFG_BASE);
   localparam logic [ADDR_W:0] CFG_HI  = (ADDR_W+1)'(CFG_BASE + 2*NUM_CFG);

   if (CFG_BASE < INFO_SPAN) begin : g_bad_base
      $error("attr_decode: register bank overlaps information area");
   end
   if (CFG_BASE % 2 != 0) begin : g_bad_align
      $error("attr_decode: register bank must start on an even address");
   end
   if (CFG_BASE + 2*NUM_CFG > (1 << ADDR_W)) begin : g_bad_top
      $error("attr_decode: register bank exceeds address space");
   end

   logic              sel;
   logic [ADDR_W:0]   a_ext;
   logic [ADDR_W:0]   off;

   assign sel    = !reg_sel_n && !ce_lo_n;
   assign rd_acc = sel && !oe_n && we_n;
   assign wr_acc = sel && !we_n && oe_n;
   assign a_ext  = {1'b0, addr};
   assign off    = a_ext - CFG_LO;
   assign odd    = addr[0];
   assign cfg_idx = off[IDX_W:1];

   always_comb begin
      if (a_ext < INFO_HI)
         region = RGN_INFO;
      else if (a_ext >= CFG_LO && a_ext < CFG_HI)
         region = RGN_CFG;
      else
         region = RGN_NONE;
   end
endmodule

// File: rtl/attr_cfg_regs.sv
module attr_cfg_regs
   import attr_space_pkg::*;
#(
   parameter int NUM_CFG  = 4,
   parameter int SRST_BIT = 7,
   parameter int IEN_BIT  = 6,
   localparam int IDX_W   = $clog2(NUM_CFG)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              idx,
   input  logic [BYTE_W-1:0]             wdata,
   output logic [BYTE_W-1:0]             cfg_rdata,
   output logic [NUM_CFG-1:0][BYTE_W-1:0] cfg_view,
   output logic                          srst,
   output logic                          ien
);
   localparam logic [BYTE_W-1:0] SRST_ONLY = BYTE_W'(1) << SRST_BIT;

   if (NUM_CFG < 2) begin : g_bad_num
      $error("attr_cfg_regs: at least two registers required");
   end
   if (SRST_BIT == IEN_BIT || SRST_BIT >= BYTE_W || IEN_BIT >= BYTE_W) begin : g_bad_bits
      $error("attr_cfg_regs: control bit positions invalid");
   end

   logic [NUM_CFG-1:0][BYTE_W-1:0] q;
   logic                           srst_wr;

   assign srst_wr = wr_en && (idx == '0) && wdata[SRST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (srst_wr) begin
         for (int n = 0; n < NUM_CFG; n++)
            q[n] <= (n == 0) ? SRST_ONLY : '0;
      end else if (wr_en) begin
         for (int n = 0; n < NUM_CFG; n++)
            if (idx == IDX_W'(n)) q[n] <= wdata;
      end
   end

   assign cfg_rdata = q[idx];
   assign cfg_view  = q;
   assign srst      = q[0][SRST_BIT];
   assign ien       = q[0][IEN_BIT];

   // R8
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst_wr |=> (q[1] == '0) && (q[0] == SRST_ONLY));
endmodule

// File: rtl/attr_busy_timer.sv
module attr_busy_timer #(
   parameter int BUSY_CYC = 16,
   localparam int CNT_W   = $clog2(BUSY_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic srst,
   output logic ready
);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC);

   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("attr_busy_timer: recovery time must be at least one clock");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= CNT_LOAD;
      else if (srst)
         cnt <= CNT_LOAD;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign ready = (cnt == '0) && !srst;

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(srst) |-> !ready);

   // R7
   ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(!srst));
endmodule

// File: rtl/attr_space_ctl.sv
module attr_space_ctl
   import attr_space_pkg::*;
#(
   parameter int          ADDR_W    = 10,
   parameter int          INFO_SPAN = 256,
   parameter int          CFG_BASE  = 'h200,
   parameter int          NUM_CFG   = 4,
   parameter int          BUSY_CYC  = 16,
   parameter logic [7:0]  INFO_KEY  = 8'hA5,
   parameter bit          REG_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel_n,
   input  logic              ce_lo_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              dev_irq,
   output logic [7:0]        rdata,
   output logic              ready,
   output logic              host_irq
);
   localparam int IDX_W  = $clog2(NUM_CFG);
   localparam int INFO_AW = $clog2(INFO_SPAN);

   if (INFO_AW > ADDR_W || (1 << INFO_AW) != INFO_SPAN) begin : g_bad_span
      $error("attr_space_ctl: information span must be a power of two within the address space");
   end

   logic                           rd_acc, wr_acc, odd;
   region_e                        region;
   logic [IDX_W-1:0]               cfg_idx;
   logic [BYTE_W-1:0]              cfg_rdata, rd_val;
   logic [NUM_CFG-1:0][BYTE_W-1:0] cfg_view;
   logic                           srst, ien;

   attr_decode #(
      .ADDR_W(ADDR_W), .INFO_SPAN(INFO_SPAN), .CFG_BASE(CFG_BASE), .NUM_CFG(NUM_CFG)
   ) u_dec (
      .reg_sel_n(reg_sel_n), .ce_lo_n(ce_lo_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
      .rd_acc(rd_acc), .wr_acc(wr_acc), .region(region), .odd(odd), .cfg_idx(cfg_idx)
   );

   attr_cfg_regs #(.NUM_CFG(NUM_CFG)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_acc && region == RGN_CFG && !odd),
      .idx(cfg_idx), .wdata(wdata), .cfg_rdata(cfg_rdata), .cfg_view(cfg_view),
      .srst(srst), .ien(ien)
   );

   attr_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
      .clk(clk), .rst_n(rst_n), .srst(srst), .ready(ready)
   );

   always_comb begin
      rd_val = '1;
      if (rd_acc && !odd) begin
         if (region == RGN_INFO)
            rd_val = info_byte(int'(addr[INFO_AW-1:1]), INFO_KEY);
         else if (region == RGN_CFG)
            rd_val = cfg_rdata;
      end
   end

   if (REG_RDATA) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata <= '1;
         else
            rdata <= rd_val;
      end

      // R11
      rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(rd_acc) |-> rdata == 8'hFF);

      // R3
      odd_info_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rd_acc && region == RGN_INFO && odd) |-> rdata == 8'hFF);
   end else begin : g_rd_comb
      assign rdata = rd_val;
   end

   assign host_irq = dev_irq && ien;

   // R4
   info_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && region == RGN_INFO) |=> $stable(cfg_view));
endmodule

// File: tb/attr_space_ctl_bench.sv
module attr_space_ctl_bench;
   localparam int BUSY = 16;
   localparam int NCFG = 4;
   localparam int KEY  = 'hA5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_sel_n = 1'b1, ce_lo_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [9:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       dev_irq = 1'b0;
   logic [7:0] rdata;
   logic       ready, host_irq;

   attr_space_ctl u_attr_space_ctl (
      .clk(clk), .rst_n(rst_n), .reg_sel_n(reg_sel_n), .ce_lo_n(ce_lo_n),
      .oe_n(oe_n), .we_n(we_n), .addr(addr), .wdata(wdata), .dev_irq(dev_irq),
      .rdata(rdata), .ready(ready), .host_irq(host_irq)
   );

   always #10 clk = ~clk;

   int    vectors = 0, miscompares = 0;
   bit    chk_on = 0;
   string tag = "R7";

   // reference model state
   int mcfg [NCFG] = '{default: 0};
   int mcnt = BUSY;
   int mrd  = 'hFF;
   bit m_rd, m_wr;

   function automatic int lookup(input int a);
      if (a < 256) return (a % 2) ? 'hFF : (((a / 2) ^ KEY) & 'hFF);
      if (a >= 'h200 && a < 'h200 + 2*NCFG && (a % 2) == 0) return mcfg[(a - 'h200) / 2];
      return 'hFF;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (mcfg[n]) mcfg[n] = 0;
         mcnt = BUSY;
         mrd  = 'hFF;
      end else begin
         m_rd = !reg_sel_n && !ce_lo_n && !oe_n && we_n;
         m_wr = !reg_sel_n && !ce_lo_n && !we_n && oe_n;
         mrd  = m_rd ? lookup(int'(addr)) : 'hFF;
         if (mcfg[0][7]) mcnt = BUSY;
         else if (mcnt > 0) mcnt = mcnt - 1;
         if (m_wr && addr >= 10'h200 && addr < 10'(('h200) + 2*NCFG) && !addr[0]) begin
            if (addr == 10'h200 && wdata[7]) begin
               foreach (mcfg[n]) mcfg[n] = 0;
               mcfg[0] = 'h80;
            end else begin
               mcfg[(int'(addr) - 'h200) / 2] = int'(wdata);
            end
         end
      end
   end

   always @(negedge clk) begin
      if (chk_on) begin
         bit exp_ready, exp_irq;
         exp_ready = (mcnt == 0) && !mcfg[0][7];
         exp_irq   = dev_irq && mcfg[0][6];
         vectors++;
         if (rdata !== 8'(mrd)) begin
            miscompares++;
            $display("FAIL %s rdata actual=%02h expected=%02h @%0t", tag, rdata, 8'(mrd), $time);
         end
         if (ready !== exp_ready) begin
            miscompares++;
            $display("FAIL %s ready actual=%b expected=%b @%0t", tag, ready, exp_ready, $time);
         end
         if (host_irq !== exp_irq) begin
            miscompares++;
            $display("FAIL %s host_irq actual=%b expected=%b @%0t", tag, host_irq, exp_irq, $time);
         end
      end
   end

   task automatic drive(input bit rs, input bit ce, input bit oe, input bit we,
                        input int a, input int d);
      @(posedge clk); #4;
      reg_sel_n = rs; ce_lo_n = ce; oe_n = oe; we_n = we;
      addr = 10'(a); wdata = 8'(d);
      @(posedge clk); #4;
      reg_sel_n = 1; ce_lo_n = 1; oe_n = 1; we_n = 1;
   endtask

   task automatic rd(input int a);
      drive(0, 0, 0, 1, a, 0);
   endtask

   task automatic wr(input int a, input int d);
      drive(0, 0, 1, 0, a, d);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      #4_000_000;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      // R7: reset state and recovery time after hardware reset
      tag = "R7";
      @(posedge clk); #4; chk_on = 1;
      idle(4);
      #4 rst_n = 1;
      idle(BUSY + 4);
      // R2: every information byte on even addresses
      tag = "R2";
      for (int i = 0; i < 128; i++) rd(2 * i);
      // R3: odd addresses in the information area
      tag = "R3";
      rd(1); rd(3); rd(129); rd(255);
      // R5: register bank read/write
      tag = "R5";
      wr('h202, 'h3C); wr('h204, 'hC3); wr('h206, 'h5A); wr('h200, 'h45);
      rd('h200); rd('h202); rd('h204); rd('h206);
      // R10: interrupt gating
      tag = "R10";
      @(posedge clk); #4 dev_irq = 1; idle(2);
      wr('h200, 'h05); idle(2);
      @(posedge clk); #4 dev_irq = 0; idle(1);
      @(posedge clk); #4 dev_irq = 1; wr('h200, 'h40); idle(2);
      // R4: information area is read-only
      tag = "R4";
      wr('h10, 'h00); wr('h11, 'h77); wr('h00, 'hFF);
      rd('h10); rd('h200); rd('h202);
      // R6: holes and odd register offsets
      tag = "R6";
      rd('h100); rd('h203); rd('h300); rd('h1FE); rd('h208);
      wr('h208, 'h11); wr('h203, 'h22); wr('h3FE, 'h33);
      rd('h202); rd('h204); rd('h206);
      // R1: strobe qualification
      tag = "R1";
      drive(1, 0, 0, 1, 'h000, 0);
      drive(0, 1, 0, 1, 'h000, 0);
      drive(0, 0, 0, 0, 'h202, 'h99);
      drive(1, 0, 1, 0, 'h202, 'h98);
      drive(0, 1, 1, 0, 'h204, 'h97);
      rd('h202); rd('h204);
      // R8: soft reset clears configuration and drops ready
      tag = "R8";
      wr('h200, 'hC7);
      rd('h200); rd('h202); rd('h204); rd('h206);
      idle(BUSY + 2);
      // R9: recovery after soft reset release
      tag = "R9";
      wr('h200, 'h40);
      idle(BUSY + 3);
      rd('h202);
      // R11: idle cycles return all ones
      tag = "R11";
      idle(5);
      chk_on = 0;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule